// File: doc/BRIEF.md
# Six-Mode Programmable Counter Channel

This block is one 16-bit down-counting timer channel. A clock, a gate input and one output pin set its behaviour. A mode strobe carries a 3-bit mode code into the channel. A count strobe carries a 16-bit starting value. From that point the channel works by itself. Depending on the mode, it raises a flag at terminal count, produces a retriggerable one-shot pulse, divides the clock into a periodic tick, produces a square wave, or gives a one-clock strobe after a delay. That delay starts either from the count write or from a gate edge.

The count arrives as one binary word. Byte sequencing, bus decoding and decimal counting belong to the logic around the channel. The live count is visible at all times so that a host can read it. A starting value of zero stands for 65536 clocks.

Top module: `prog_count_channel`

## Requirements
- R1: After reset, `out` is 1, `count_now` is 0, and nothing counts until a mode and a count are written.
- R2: The mode code selects the behaviour as follows.
  - 0: terminal-count flag.
  - 1: one-shot.
  - 2: rate divider.
  - 3: square wave.
  - 4: software strobe.
  - 5: gate strobe.
  - Codes 6 and 7 act exactly as 2 and 3, because bit 2 is ignored whenever bits 1:0 are 2'b10 or 2'b11.
- R3: Mode 0 has these steps.
  - `out` falls on the clock edge that takes the mode write.
  - The count is loaded on the edge after the count write, and `out` is 0 at that point.
  - The count then decrements once per enabled clock.
  - `out` rises on the edge where the count reaches 0, and it stays 1.
- R4: In modes 0, 2, 3 and 4 the count advances only on edges where `gate` is 1. A low gate holds the count unchanged.
- R5: Mode 1 behaves as a one-shot.
  - `out` is 1 after the mode write and stays 1 after a count write until a trigger.
  - A trigger is an edge where `gate` is 1 and was 0 at the previous edge.
  - A trigger loads the count and drives `out` low for exactly N clocks.
  - A steady gate level has no effect.
- R6: Mode 1 can be retriggered. A trigger during a pulse reloads N and extends the pulse. A count written during a pulse leaves that pulse unchanged and is used from the next trigger.
- R7: In mode 2, `out` is low for one clock while the count is 1 and high for N-1 clocks. The count then reloads N and never reaches 0.
- R8: In mode 3, `out` is high for ceil(N/2) clocks and low for floor(N/2) clocks, and this repeats. For odd N the extra clock goes to the high half.
- R9: In mode 4, `out` stays 1 after the load and falls for exactly one clock when the count reaches 0. It then stays 1 and the count holds at 0.
- R10: In mode 5, nothing counts until a gate rising edge. The edge loads N. `out` is high for N clocks, low for one, then high again. The next rising edge repeats the cycle.
- R11: A count value of 0 is loaded as 0 and then decrements to 65535, which gives a span of 65536 clocks.
- R12: In modes 2 and 3, a count written while the channel runs takes effect at the next reload. The current period finishes with the old value.
- R13: A count write in the same cycle as a mode write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset |
| gate | input | 1 | Gate: a level enable or a rising-edge trigger, depending on the mode |
| mode_wr | input | 1 | One-cycle strobe that takes `mode_sel` |
| mode_sel | input | 3 | Mode code |
| count_wr | input | 1 | One-cycle strobe that takes `count_in` |
| count_in | input | 16 | Starting count (0 means 65536) |
| out | output | 1 | Registered channel output |
| count_now | output | 16 | Live counter value |

## Verification
Several properties are checked on every clock edge:
- a low gate freezes the count in the gated modes;
- a mode-1 trigger always drives `out` low on the next edge;
- mode 2 reloads from the preset when it leaves a count of 1;
- a strobe low never lasts more than one clock;
- mode codes 6 and 7 decode as 2 and 3;
- a count write dropped by a simultaneous mode write leaves the preset unchanged.

Some behaviours cover many cycles and only the bench scenarios show them:
- the high and low lengths of whole waveforms;
- the length of a one-shot pulse;
- how a retrigger or a mid-period count write stretches or reshapes a pulse;
- the 65536 wrap on a zero count;
- the rearming of the gate strobe.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam int MODE_BITS = 3;

  typedef enum logic [MODE_BITS-1:0] {
    M_TC       = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_e;

  // Bit 2 is a don't-care for the two periodic modes.
  function automatic mode_e decode_mode(input logic [MODE_BITS-1:0] code);
    mode_e m;
    if (code[1:0] == 2'b10) begin
      m = M_RATE;
    end else if (code[1:0] == 2'b11) begin
      m = M_SQUARE;
    end else begin
      case (code)
        3'd1:    m = M_ONESHOT;
        3'd4:    m = M_SWSTROBE;
        3'd5:    m = M_HWSTROBE;
        default: m = M_TC;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/pcc_gate_edge.sv
module pcc_gate_edge (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  output logic rise
);

  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= gate;
  end

  // High at an edge where gate is 1 and it was 0 at the previous edge.
  assign rise = gate & ~gate_q;

endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_wr,
  input  logic [MODE_BITS-1:0] mode_sel,
  input  logic                 count_wr,
  input  logic [COUNT_W-1:0]   count_in,
  input  logic                 running,
  input  logic                 gate_rise,
  output mode_e                mode_q,
  output logic [COUNT_W-1:0]   preset_q,
  output logic                 load_now,
  output logic                 trig,
  output logic                 flush,
  output logic                 flush_low
);

  logic pend_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_TC;
      preset_q <= '0;
      pend_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      pend_q <= 1'b0;
      if (mode_wr) begin
        mode_q  <= decode_mode(mode_sel);
        armed_q <= 1'b0;
      end else if (count_wr) begin
        preset_q <= count_in;
        case (mode_q)
          M_ONESHOT, M_HWSTROBE: armed_q <= 1'b1;
          M_RATE, M_SQUARE:      pend_q  <= ~running;
          default:               pend_q  <= 1'b1;
        endcase
      end
    end
  end

  assign load_now  = pend_q;
  assign trig      = armed_q & gate_rise;
  assign flush     = mode_wr;
  assign flush_low = (decode_mode(mode_sel) == M_TC);

  a_r2_alias_rate: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && mode_sel[1:0] == 2'b10) |=> (mode_q == M_RATE));

  a_r2_alias_square: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && mode_sel[1:0] == 2'b11) |=> (mode_q == M_SQUARE));

  a_r13_count_dropped: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && count_wr) |=> $stable(preset_q));

endmodule

// File: rtl/pcc_core.sv
module pcc_core
  import pcc_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  mode_e              mode,
  input  logic [COUNT_W-1:0] preset,
  input  logic               load_now,
  input  logic               trig,
  input  logic               flush,
  input  logic               flush_low,
  input  logic               gate,
  output logic [COUNT_W-1:0] cnt_o,
  output logic               out_o,
  output logic               running
);

  localparam logic [COUNT_W-1:0] ONE  = COUNT_W'(1);
  localparam logic [COUNT_W-1:0] TWO  = COUNT_W'(2);
  localparam logic [COUNT_W:0]   FULL = {1'b1, {COUNT_W{1'b0}}};

  logic [COUNT_W-1:0] cnt_q;
  logic [COUNT_W:0]   half_q;
  logic               out_q;
  logic               active_q;

  logic [COUNT_W-1:0] dec;
  logic [COUNT_W:0]   eff;
  logic               gated_mode;
  logic               strobe_mode;
  logic               step;

  assign dec         = cnt_q - ONE;
  assign eff         = (preset == '0) ? FULL : {1'b0, preset};
  assign gated_mode  = mode inside {M_TC, M_RATE, M_SQUARE, M_SWSTROBE};
  assign strobe_mode = mode inside {M_SWSTROBE, M_HWSTROBE};
  assign step        = active_q && (gate || !gated_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      half_q   <= '0;
      out_q    <= 1'b1;
      active_q <= 1'b0;
    end else if (flush) begin
      active_q <= 1'b0;
      out_q    <= ~flush_low;
    end else begin
      if (strobe_mode && !out_q) out_q <= 1'b1;
      if (load_now || trig) begin
        cnt_q    <= preset;
        half_q   <= eff >> 1;
        active_q <= 1'b1;
        out_q    <= !(mode == M_TC || mode == M_ONESHOT);
      end else if (step) begin
        case (mode)
          M_TC: begin
            cnt_q <= dec;
            if (cnt_q == ONE) out_q <= 1'b1;
          end
          M_ONESHOT: begin
            cnt_q <= dec;
            if (cnt_q == ONE) begin
              out_q    <= 1'b1;
              active_q <= 1'b0;
            end
          end
          M_RATE: begin
            if (cnt_q == ONE) begin
              cnt_q <= preset;
              out_q <= 1'b1;
            end else begin
              cnt_q <= dec;
              if (cnt_q == TWO) out_q <= 1'b0;
            end
          end
          M_SQUARE: begin
            if (cnt_q == ONE) begin
              cnt_q  <= preset;
              half_q <= eff >> 1;
              out_q  <= 1'b1;
            end else begin
              cnt_q <= dec;
              if ({1'b0, dec} == half_q) out_q <= 1'b0;
            end
          end
          M_SWSTROBE, M_HWSTROBE: begin
            cnt_q <= dec;
            if (cnt_q == ONE) begin
              out_q    <= 1'b0;
              active_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign out_o   = out_q;
  assign running = active_q;

  // R4: a low gate freezes the count in the gated modes
  a_r4_gate_hold: assert property (@(posedge clk) disable iff (rst)
    (active_q && !gate && gated_mode && !flush && !load_now) |=> $stable(cnt_q));

  // R5: a trigger in one-shot mode starts the low pulse on the next edge
  a_r5_trigger_low: assert property (@(posedge clk) disable iff (rst)
    (trig && mode == M_ONESHOT && !flush) |=> !out_q);

  // R7: leaving a count of 1 in rate mode reloads the preset
  a_r7_rate_reload: assert property (@(posedge clk) disable iff (rst)
    (mode == M_RATE && active_q && gate && cnt_q == ONE && !flush && !load_now)
      |=> (cnt_q == $past(preset)));

  // R9 and R10: a strobe low lasts one clock
  a_r9_strobe_one_clk: assert property (@(posedge clk) disable iff (rst)
    (strobe_mode && !out_q && !flush) |=> out_q);

endmodule

// File: rtl/prog_count_channel.sv
module prog_count_channel
  import pcc_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gate,
  input  logic                 mode_wr,
  input  logic [MODE_BITS-1:0] mode_sel,
  input  logic                 count_wr,
  input  logic [COUNT_W-1:0]   count_in,
  output logic                 out,
  output logic [COUNT_W-1:0]   count_now
);

  mode_e              mode_q;
  logic [COUNT_W-1:0] preset_q;
  logic               load_now;
  logic               trig;
  logic               flush;
  logic               flush_low;
  logic               gate_rise;
  logic               running;

  pcc_gate_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .gate (gate),
    .rise (gate_rise)
  );

  pcc_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (mode_wr),
    .mode_sel  (mode_sel),
    .count_wr  (count_wr),
    .count_in  (count_in),
    .running   (running),
    .gate_rise (gate_rise),
    .mode_q    (mode_q),
    .preset_q  (preset_q),
    .load_now  (load_now),
    .trig      (trig),
    .flush     (flush),
    .flush_low (flush_low)
  );

  pcc_core #(.COUNT_W(COUNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .preset    (preset_q),
    .load_now  (load_now),
    .trig      (trig),
    .flush     (flush),
    .flush_low (flush_low),
    .gate      (gate),
    .cnt_o     (count_now),
    .out_o     (out),
    .running   (running)
  );

endmodule

// File: tb/prog_count_channel_tb.sv
module prog_count_channel_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gate = 1'b1;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic        count_wr = 1'b0;
  logic [15:0] count_in = 16'd0;
  logic        out;
  logic [15:0] count_now;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  prog_count_channel u_dut (
    .clk       (clk),
    .rst       (rst),
    .gate      (gate),
    .mode_wr   (mode_wr),
    .mode_sel  (mode_sel),
    .count_wr  (count_wr),
    .count_in  (count_in),
    .out       (out),
    .count_now (count_now)
  );

  typedef struct packed {
    logic [2:0]  code;
    logic [15:0] n;
    logic [15:0] hi;
    logic [15:0] lo;
  } wave_t;

  // Periodic-mode vectors: mode code, count, expected high and low lengths.
  localparam int NV = 8;
  localparam wave_t VECS [NV] = '{
    '{3'b010, 16'd5, 16'd4, 16'd1},
    '{3'b110, 16'd7, 16'd6, 16'd1},
    '{3'b010, 16'd2, 16'd1, 16'd1},
    '{3'b011, 16'd6, 16'd3, 16'd3},
    '{3'b011, 16'd7, 16'd4, 16'd3},
    '{3'b111, 16'd5, 16'd3, 16'd2},
    '{3'b011, 16'd2, 16'd1, 16'd1},
    '{3'b011, 16'd3, 16'd2, 16'd1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_mode(input logic [2:0] m);
    @(negedge clk);
    mode_wr  = 1'b1;
    mode_sel = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic write_count(input logic [15:0] n);
    @(negedge clk);
    count_wr = 1'b1;
    count_in = n;
    @(negedge clk);
    count_wr = 1'b0;
  endtask

  task automatic wait_low();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (out !== 1'b0 && g < 2000);
  endtask

  task automatic low_len(output int n);
    n = 0;
    wait_low();
    while (out === 1'b0 && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure_wave(output int hi, output int lo);
    hi = 0;
    lo = 0;
    wait_low();
    while (out === 1'b0 && lo < 2000) begin
      lo++;
      @(negedge clk);
    end
    while (out === 1'b1 && hi < 2000) begin
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic gate_pulse();
    @(negedge clk);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
  endtask

  task automatic high_until_strobe(output int hi);
    hi = 0;
    @(negedge clk);
    while (out === 1'b1 && hi < 2000) begin
      hi++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<50000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo, n;
    logic [15:0] c0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "out after reset", out, 1);
    chk("R1", "count after reset", count_now, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "idle out", out, 1);
    chk("R1", "idle count", count_now, 0);

    // R7, R8, R2: table of periodic waveforms
    for (int i = 0; i < NV; i++) begin
      write_mode(VECS[i].code);
      write_count(VECS[i].n);
      measure_wave(hi, lo);
      if (VECS[i].code[1:0] == 2'b10) begin
        chk(VECS[i].code[2] ? "R2/R7" : "R7", "rate high length", hi, VECS[i].hi);
        chk(VECS[i].code[2] ? "R2/R7" : "R7", "rate low length", lo, VECS[i].lo);
      end else begin
        chk(VECS[i].code[2] ? "R2/R8" : "R8", "square high length", hi, VECS[i].hi);
        chk(VECS[i].code[2] ? "R2/R8" : "R8", "square low length", lo, VECS[i].lo);
      end
    end

    // R3: mode 0 terminal count
    write_mode(3'd0);
    chk("R3", "out after mode 0 write", out, 0);
    write_count(16'd5);
    @(negedge clk);
    chk("R3", "count loaded", count_now, 5);
    chk("R3", "out low while counting", out, 0);
    repeat (4) @(negedge clk);
    chk("R3", "count before zero", count_now, 1);
    chk("R3", "out before zero", out, 0);
    @(negedge clk);
    chk("R3", "count at zero", count_now, 0);
    chk("R3", "out at zero", out, 1);
    repeat (3) @(negedge clk);
    chk("R3", "out stays high", out, 1);

    // R4: low gate holds the count
    write_count(16'd5);
    @(negedge clk);
    gate = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4", "count held while gate low", count_now, 5);
    gate = 1'b1;
    @(negedge clk);
    chk("R4", "count resumes", count_now, 4);

    // R11: zero means 65536
    write_count(16'd0);
    @(negedge clk);
    chk("R11", "zero loaded", count_now, 0);
    chk("R11", "out low after zero load", out, 0);
    @(negedge clk);
    chk("R11", "wrap to 65535", count_now, 16'hFFFF);

    // R13: a count write alongside a mode write is dropped
    @(negedge clk);
    mode_wr  = 1'b1;
    mode_sel = 3'd4;
    count_wr = 1'b1;
    count_in = 16'd3;
    @(negedge clk);
    mode_wr  = 1'b0;
    count_wr = 1'b0;
    c0 = count_now;
    repeat (6) @(negedge clk);
    chk("R13", "count unchanged", count_now, c0);
    chk("R13", "no strobe", out, 1);

    // R9: software strobe
    write_count(16'd3);
    @(negedge clk);
    chk("R9", "count loaded", count_now, 3);
    chk("R9", "out high after load", out, 1);
    low_len(n);
    chk("R9", "strobe length", n, 1);
    repeat (5) @(negedge clk);
    chk("R9", "no second strobe", out, 1);
    chk("R9", "count holds at zero", count_now, 0);

    // R5: one-shot
    gate = 1'b0;
    write_mode(3'd1);
    chk("R5", "out after mode 1 write", out, 1);
    write_count(16'd3);
    repeat (3) @(negedge clk);
    chk("R5", "no pulse before trigger", out, 1);
    gate = 1'b1;
    low_len(n);
    chk("R5", "pulse length", n, 3);
    repeat (5) @(negedge clk);
    chk("R5", "steady gate has no effect", out, 1);

    // R6: retrigger extends the pulse
    gate_pulse();
    @(negedge clk);
    chk("R6", "pulse started", out, 0);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    low_len(n);
    chk("R6", "retriggered remainder", n, 3);

    // R6: count written mid-pulse waits for the next trigger
    gate_pulse();
    fork
      low_len(n);
      write_count(16'd6);
    join
    chk("R6", "current pulse unchanged", n, 3);
    gate_pulse();
    low_len(n);
    chk("R6", "new count at next trigger", n, 6);

    // R10: gate strobe
    gate = 1'b0;
    write_mode(3'd5);
    write_count(16'd4);
    repeat (3) @(negedge clk);
    chk("R10", "waits for trigger", out, 1);
    @(negedge clk);
    gate = 1'b1;
    high_until_strobe(hi);
    chk("R10", "delay to strobe", hi, 4);
    @(negedge clk);
    chk("R10", "strobe one clock", out, 1);
    gate_pulse();
    high_until_strobe(hi);
    chk("R10", "rearmed delay", hi, 4);

    // R12: rate-mode rewrite takes effect at the next reload
    gate = 1'b1;
    write_mode(3'd2);
    write_count(16'd4);
    wait_low();
    write_count(16'd6);
    measure_wave(hi, lo);
    chk("R12", "old low pulse", lo, 1);
    chk("R12", "new high length", hi, 5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule